// File: doc/BRIEF.md
# Display Bus Strobe Sequencer

This block sits between a processor bus and a parallel display module. A single-cycle request carries a read/write flag, an address and write data. The block decodes the address into one of three transfer kinds: a data transfer, a command transfer, or a display reset. It then plays out a timed strobe sequence on the display pins. Every interval of that sequence is counted in pulses of a tick enable, nominally 10 MHz, that is supplied from outside.

The read/write flag alone decides the direction of a data or command transfer. The address alone decides the kind. A reset is accepted only as a write at its own address. A data or command access works in three steps: the select lines are set up, an enable strobe of fixed length follows, then one quiet tick ends the access. On reads, the display bus is captured at the tick edge that closes the strobe. A reset drives the display's reset line for a fixed time, then waits out a recovery time. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `dispbus_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, disp_en_o and disp_oe_o are 0, rdata_o is 0 and disp_rst_o is inactive (1, since the reset pin defaults to active low).
- R2: A request at DATA_ADDR (default 0x3F00000) starts a data transfer with disp_dc_o=1. A request at CMD_ADDR (default 0x3F00200) starts a command transfer with disp_dc_o=0. wr_i=1 is a write and gives disp_rw_o=0, while wr_i=0 is a read and gives disp_rw_o=1.
- R3: A write at RST_ADDR (default 0x3F00100) starts a display reset. No enable strobe is produced during it.
- R4: A read at RST_ADDR, or a request at any other address, is ignored: busy_o stays 0 and no done pulse follows.
- R5: disp_dc_o, disp_rw_o and disp_dout_o take their values in the cycle after acceptance and hold them until done. disp_en_o rises on the second tick after acceptance, which gives at least one full tick of setup.
- R6: disp_en_o stays high for exactly 3 ticks. One further tick follows with disp_en_o low, and done comes at the end of it.
- R7: On a read, rdata_o takes disp_din_i as sampled at the tick edge that ends the last strobe tick. It keeps that value until the next read completes.
- R8: A reset drives disp_rst_o active from the cycle after acceptance until the 11th tick after acceptance, which is at least 10 full ticks. It then waits 10 ticks before done.
- R9: busy_o is 1 from the cycle after acceptance until the sequence ends. done_o is a one-cycle pulse in the cycle where busy_o falls.
- R10: Requests that arrive while busy_o is 1 are ignored. They neither alter the running transfer nor start another one afterwards.
- R11: disp_oe_o is 1 only while a write transfer is busy, and it is 0 on reads and resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timing tick enable (10 MHz nominal) |
| req_i | input | 1 | Access request, one cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (26) | Access address |
| wdata_i | input | DW (16) | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rdata_o | output | DW (16) | Captured read data |
| disp_dc_o | output | 1 | 1 = data, 0 = command |
| disp_rw_o | output | 1 | 1 = read, 0 = write |
| disp_en_o | output | 1 | Enable strobe |
| disp_rst_o | output | 1 | Display reset line (polarity set by parameter) |
| disp_oe_o | output | 1 | Drive enable for the display data bus |
| disp_dout_o | output | DW (16) | Data driven to the display |
| disp_din_i | input | DW (16) | Data returned by the display |

## Verification
The assertions assume that tick_i is a single-cycle pulse with at least one idle cycle between pulses. They also assume that the request inputs only matter in the cycle where req_i is high. The stimulus raises tick_i on every second clock and drives all inputs one time unit after the rising edge. It changes the returned display data only between tick edges, so each strobe tick samples a known value. Requests that arrive while busy are sent with an address and data that differ from the running access, so a violation would show up at the outputs.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

   typedef enum logic [1:0] {
      XFER_NONE = 2'd0,
      XFER_DATA = 2'd1,
      XFER_CMD  = 2'd2,
      XFER_RST  = 2'd3
   } xfer_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_RACT   = 3'd4,
      ST_RWAIT  = 3'd5
   } seq_state_e;

endpackage

// File: rtl/dispbus_decode.sv
module dispbus_decode
   import dispbus_pkg::*;
#(
   parameter int unsigned ADDR_W = 26,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 26'h3F00000,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 26'h3F00200,
   parameter logic [ADDR_W-1:0] RST_ADDR  = 26'h3F00100
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output xfer_e             kind_o
);

   always_comb begin
      kind_o = XFER_NONE;
      if (addr_i == DATA_ADDR)
         kind_o = XFER_DATA;
      else if (addr_i == CMD_ADDR)
         kind_o = XFER_CMD;
      else if ((addr_i == RST_ADDR) && wr_i)
         kind_o = XFER_RST;
   end

endmodule

// File: rtl/dispbus_seq.sv
module dispbus_seq
   import dispbus_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned SETUP_TICKS = 1,
   parameter int unsigned EN_TICKS    = 3,
   parameter int unsigned HOLD_TICKS  = 1,
   parameter int unsigned RST_TICKS   = 10,
   parameter int unsigned WAIT_TICKS  = 10
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          req_i,
   input  logic          wr_i,
   input  xfer_e         kind_i,
   input  logic [DW-1:0] wdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          dc_o,
   output logic          rw_o,
   output logic          en_o,
   output logic          oe_o,
   output logic          rst_act_o,
   output logic [DW-1:0] dout_o,
   output logic          cap_o
);

   localparam int unsigned MAX_A = (SETUP_TICKS > RST_TICKS) ? SETUP_TICKS : RST_TICKS;
   localparam int unsigned MAX_B = (EN_TICKS > WAIT_TICKS) ? EN_TICKS : WAIT_TICKS;
   localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned MAX_T = (MAX_C > HOLD_TICKS) ? MAX_C : HOLD_TICKS;
   localparam int unsigned CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] LIM_SETUP = CNT_W'(SETUP_TICKS);
   localparam logic [CNT_W-1:0] LIM_EN    = CNT_W'(EN_TICKS - 1);
   localparam logic [CNT_W-1:0] LIM_HOLD  = CNT_W'(HOLD_TICKS - 1);
   localparam logic [CNT_W-1:0] LIM_RACT  = CNT_W'(RST_TICKS);
   localparam logic [CNT_W-1:0] LIM_RWAIT = CNT_W'(WAIT_TICKS - 1);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             accept;

   assign accept = req_i && (state_q == ST_IDLE) && (kind_i != XFER_NONE);
   assign busy_o = (state_q != ST_IDLE);
   assign cap_o  = (state_q == ST_STROBE) && tick_i && (cnt_q == LIM_EN) && rw_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         done_o    <= 1'b0;
         dc_o      <= 1'b0;
         rw_o      <= 1'b0;
         en_o      <= 1'b0;
         oe_o      <= 1'b0;
         rst_act_o <= 1'b0;
         dout_o    <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  cnt_q <= '0;
                  if (kind_i == XFER_RST) begin
                     state_q   <= ST_RACT;
                     rst_act_o <= 1'b1;
                  end else begin
                     state_q <= ST_SETUP;
                     dc_o    <= (kind_i == XFER_DATA);
                     rw_o    <= !wr_i;
                     oe_o    <= wr_i;
                     dout_o  <= wdata_i;
                  end
               end
            end
            ST_SETUP: if (tick_i) begin
               if (cnt_q == LIM_SETUP) begin
                  state_q <= ST_STROBE;
                  en_o    <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_STROBE: if (tick_i) begin
               if (cnt_q == LIM_EN) begin
                  state_q <= ST_HOLD;
                  en_o    <= 1'b0;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_HOLD: if (tick_i) begin
               if (cnt_q == LIM_HOLD) begin
                  state_q <= ST_IDLE;
                  oe_o    <= 1'b0;
                  done_o  <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RACT: if (tick_i) begin
               if (cnt_q == LIM_RACT) begin
                  state_q   <= ST_RWAIT;
                  rst_act_o <= 1'b0;
                  cnt_q     <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RWAIT: if (tick_i) begin
               if (cnt_q == LIM_RWAIT) begin
                  state_q <= ST_IDLE;
                  done_o  <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dispbus_rcap.sv
module dispbus_rcap #(
   parameter int unsigned DW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cap_i,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] rdata_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         rdata_o <= '0;
      else if (cap_i)
         rdata_o <= din_i;
   end

endmodule

// File: rtl/dispbus_ctrl.sv
module dispbus_ctrl
   import dispbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 26,
   parameter int unsigned DW          = 16,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 26'h3F00000,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 26'h3F00200,
   parameter logic [ADDR_W-1:0] RST_ADDR  = 26'h3F00100,
   parameter int unsigned SETUP_TICKS = 1,
   parameter int unsigned EN_TICKS    = 3,
   parameter int unsigned HOLD_TICKS  = 1,
   parameter int unsigned RST_TICKS   = 10,
   parameter int unsigned WAIT_TICKS  = 10,
   parameter bit          RST_ACT_LOW = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DW-1:0]     rdata_o,
   output logic              disp_dc_o,
   output logic              disp_rw_o,
   output logic              disp_en_o,
   output logic              disp_rst_o,
   output logic              disp_oe_o,
   output logic [DW-1:0]     disp_dout_o,
   input  logic [DW-1:0]     disp_din_i
);

   if (DW < 1) begin : g_bad_dw
      $error("dispbus_ctrl: DW must be at least 1");
   end
   if (EN_TICKS < 1 || HOLD_TICKS < 1 || WAIT_TICKS < 1) begin : g_bad_len
      $error("dispbus_ctrl: strobe, hold and wait lengths must be at least 1");
   end
   if (DATA_ADDR == CMD_ADDR || DATA_ADDR == RST_ADDR || CMD_ADDR == RST_ADDR) begin : g_bad_map
      $error("dispbus_ctrl: transfer addresses must differ");
   end

   xfer_e kind;
   logic  rst_act;
   logic  cap;

   dispbus_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_ADDR (DATA_ADDR),
      .CMD_ADDR  (CMD_ADDR),
      .RST_ADDR  (RST_ADDR)
   ) i_decode (
      .wr_i   (wr_i),
      .addr_i (addr_i),
      .kind_o (kind)
   );

   dispbus_seq #(
      .DW          (DW),
      .SETUP_TICKS (SETUP_TICKS),
      .EN_TICKS    (EN_TICKS),
      .HOLD_TICKS  (HOLD_TICKS),
      .RST_TICKS   (RST_TICKS),
      .WAIT_TICKS  (WAIT_TICKS)
   ) i_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .req_i     (req_i),
      .wr_i      (wr_i),
      .kind_i    (kind),
      .wdata_i   (wdata_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .dc_o      (disp_dc_o),
      .rw_o      (disp_rw_o),
      .en_o      (disp_en_o),
      .oe_o      (disp_oe_o),
      .rst_act_o (rst_act),
      .dout_o    (disp_dout_o),
      .cap_o     (cap)
   );

   dispbus_rcap #(
      .DW (DW)
   ) i_rcap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (cap),
      .din_i   (disp_din_i),
      .rdata_o (rdata_o)
   );

   if (RST_ACT_LOW) begin : g_rst_low
      assign disp_rst_o = !rst_act;
   end else begin : g_rst_high
      assign disp_rst_o = rst_act;
   end

endmodule

// File: rtl/dispbus_ctrl_chk.sv
module dispbus_ctrl_chk #(
   parameter int unsigned DW          = 16,
   parameter bit          RST_ACT_LOW = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          tick_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          disp_dc_o,
   input logic          disp_rw_o,
   input logic          disp_en_o,
   input logic          disp_rst_o,
   input logic          disp_oe_o,
   input logic [DW-1:0] disp_dout_o
);

   logic rst_on;
   assign rst_on = RST_ACT_LOW ? !disp_rst_o : disp_rst_o;

   // R9: the strobe only appears inside a busy window
   p_en_inside_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_en_o |-> busy_o);

   // R5: the strobe starts only at a tick edge
   p_en_rise_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(disp_en_o) |-> $past(tick_i));

   // R5 and R10: the presented transfer is frozen while busy
   p_select_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ($stable(disp_dc_o) && $stable(disp_rw_o) && $stable(disp_dout_o)));

   // R3: no strobe while the display reset line is driven
   p_no_strobe_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_on |-> !disp_en_o);

   // R9: the done pulse marks the busy fall
   p_done_ends_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o)));

   // R9: done lasts a single cycle
   p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11: bus drive only on a busy write
   p_oe_write_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_oe_o |-> (busy_o && !disp_rw_o));

endmodule

bind dispbus_ctrl dispbus_ctrl_chk #(
   .DW          (DW),
   .RST_ACT_LOW (RST_ACT_LOW)
) i_dispbus_ctrl_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_i      (tick_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .disp_dc_o   (disp_dc_o),
   .disp_rw_o   (disp_rw_o),
   .disp_en_o   (disp_en_o),
   .disp_rst_o  (disp_rst_o),
   .disp_oe_o   (disp_oe_o),
   .disp_dout_o (disp_dout_o)
);

// File: tb/test_dispbus_ctrl.sv
`timescale 1ns/1ps
module test_dispbus_ctrl;

   localparam time CLK_PERIOD = 50ns;
   localparam int  TICK_DIV   = 2;
   localparam int  WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        req_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [25:0] addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic        busy_o, done_o;
   logic [15:0] rdata_o;
   logic        disp_dc_o, disp_rw_o, disp_en_o, disp_rst_o, disp_oe_o;
   logic [15:0] disp_dout_o;
   logic [15:0] disp_din_i = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dispbus_ctrl i_dispbus_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick_i),
      .req_i       (req_i),
      .wr_i        (wr_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .rdata_o     (rdata_o),
      .disp_dc_o   (disp_dc_o),
      .disp_rw_o   (disp_rw_o),
      .disp_en_o   (disp_en_o),
      .disp_rst_o  (disp_rst_o),
      .disp_oe_o   (disp_oe_o),
      .disp_dout_o (disp_dout_o),
      .disp_din_i  (disp_din_i)
   );

   // vector: [60] wr, [59:34] addr, [33:18] wdata, [17:2] din base, [1:0] kind
   // kind: 0 ignored, 1 data, 2 command, 3 reset
   localparam int NV = 8;
   localparam logic [60:0] VEC [NV] = '{
      {1'b1, 26'h3F00000, 16'hA5C3, 16'h0000, 2'd1},
      {1'b1, 26'h3F00200, 16'h002C, 16'h0000, 2'd2},
      {1'b0, 26'h3F00000, 16'h0000, 16'h1230, 2'd1},
      {1'b0, 26'h3F00200, 16'h0000, 16'h4400, 2'd2},
      {1'b1, 26'h3F00100, 16'h7777, 16'h0000, 2'd3},
      {1'b0, 26'h3F00100, 16'h0000, 16'h0000, 2'd0},
      {1'b1, 26'h3F00300, 16'h1111, 16'h0000, 2'd0},
      {1'b0, 26'h3F00004, 16'h0000, 16'h0000, 2'd0}
   };

   // monitor state, owned by the negedge process
   int          op_id = 0;
   int          last_op = 0;
   int          cyc = 0;
   int          div = 0;
   int          n_pre, n_en, n_post, n_ract, n_rwait, n_done;
   logic        seen_en, seen_rst;
   logic        dc_at, rw_at;
   logic [15:0] dout_at;
   logic [15:0] din_base = '0;
   logic        p_busy = 1'b0, p_en = 1'b0, p_rsta = 1'b0;

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      logic rsta;
      rsta = !disp_rst_o;
      cyc++;
      if (op_id != last_op) begin
         last_op = op_id;
         n_pre = 0; n_en = 0; n_post = 0; n_ract = 0; n_rwait = 0; n_done = 0;
         seen_en = 1'b0; seen_rst = 1'b0;
      end
      if (tick_i) begin
         if (p_busy && !p_en && !p_rsta && !seen_en && !seen_rst) n_pre++;
         if (p_en) n_en++;
         if (p_busy && !p_en && seen_en) n_post++;
         if (p_busy && p_rsta) n_ract++;
         if (p_busy && !p_rsta && seen_rst) n_rwait++;
      end
      if (done_o) n_done++;
      if (disp_en_o && !seen_en) begin
         seen_en = 1'b1;
         dc_at   = disp_dc_o;
         rw_at   = disp_rw_o;
         dout_at = disp_dout_o;
      end
      if (rsta && busy_o) seen_rst = 1'b1;
      disp_din_i = disp_en_o ? din_base + 16'(n_en + 1) : din_base;
      p_busy = busy_o;
      p_en   = disp_en_o;
      p_rsta = rsta;
      div    = (div == TICK_DIV - 1) ? 0 : div + 1;
      tick_i = (div == 0);
      if (cyc > WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run exceeded %0d cycles (actual %0d expected <= %0d)", WATCHDOG, cyc, WATCHDOG);
         finish_run();
      end
   end

   task automatic chk(input logic ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // runs one access; inj sends a competing request while busy
   task automatic do_op(input logic wr, input logic [25:0] addr, input logic [15:0] wd,
                        input logic [15:0] base, input int kind, input logic inj);
      logic got_done;
      @(posedge clk); #1;
      wr_i = wr; addr_i = addr; wdata_i = wd; din_base = base; req_i = 1'b1;
      op_id++;
      @(posedge clk); #1;
      req_i = 1'b0;
      if (kind == 0) begin
         chk(busy_o == 1'b0, "R4 ignored access raises no busy", busy_o, 0);
         repeat (40) @(posedge clk);
         #1;
         chk(busy_o == 1'b0 && n_done == 0, "R4 ignored access gives no done", n_done, 0);
         return;
      end
      chk(busy_o == 1'b1, "R9 busy in cycle after acceptance", busy_o, 1);
      if (kind == 3) begin
         chk(disp_rst_o == 1'b0, "R8 reset line active after acceptance", disp_rst_o, 0);
      end else begin
         chk(disp_dc_o == (kind == 1), "R2 data/command select", disp_dc_o, kind == 1);
         chk(disp_rw_o == !wr, "R2 read/write line", disp_rw_o, !wr);
         chk(disp_oe_o == wr, "R11 bus drive enable", disp_oe_o, wr);
         if (wr) chk(disp_dout_o == wd, "R5 write data presented", disp_dout_o, wd);
      end
      got_done = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(posedge clk); #1;
         if (inj && i == 3) begin
            wr_i = 1'b1; addr_i = 26'h3F00200; wdata_i = 16'hBEEF; req_i = 1'b1;
         end else begin
            req_i = 1'b0;
         end
         if (done_o) begin got_done = 1'b1; break; end
      end
      req_i = 1'b0;
      chk(got_done, "R9 done pulse arrives", got_done, 1);
      chk(busy_o == 1'b0, "R9 busy low with done", busy_o, 0);
      @(negedge clk); #1;
      if (kind == 3) begin
         chk(n_en == 0, "R3 no strobe during reset", n_en, 0);
         chk(n_ract == 11, "R8 reset line held ticks", n_ract, 11);
         chk(n_rwait == 10, "R8 recovery ticks", n_rwait, 10);
      end else begin
         chk(n_pre == 2, "R5 strobe rises on second tick", n_pre, 2);
         chk(n_en == 3, "R6 strobe length in ticks", n_en, 3);
         chk(n_post == 1, "R6 quiet tick before done", n_post, 1);
         chk(dc_at == (kind == 1), "R5 select held at strobe", dc_at, kind == 1);
         chk(rw_at == !wr, "R5 direction held at strobe", rw_at, !wr);
         if (wr) chk(dout_at == wd, "R10 data unchanged by late request", dout_at, wd);
         else    chk(rdata_o == base + 16'd3, "R7 read captured at last strobe tick", rdata_o, base + 16'd3);
      end
      @(posedge clk); #1;
      chk(done_o == 1'b0, "R9 done lasts one cycle", done_o, 0);
      chk(n_done == 1, "R9 single done per access", n_done, 1);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      chk(busy_o == 0 && done_o == 0 && disp_en_o == 0 && disp_oe_o == 0,
          "R1 reset outputs idle", {busy_o, done_o, disp_en_o, disp_oe_o}, 0);
      chk(rdata_o == 16'h0000, "R1 read data cleared", rdata_o, 0);
      chk(disp_rst_o == 1'b1, "R1 display reset inactive", disp_rst_o, 1);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      for (int v = 0; v < NV; v++) begin
         do_op(VEC[v][60], VEC[v][59:34], VEC[v][33:18], VEC[v][17:2], int'(VEC[v][1:0]), 1'b0);
      end

      // R7: a reset and ignored accesses leave the last read value in place
      chk(rdata_o == 16'h4403, "R7 read data held across later accesses", rdata_o, 16'h4403);

      // R10: request while busy is ignored and not queued
      do_op(1'b1, 26'h3F00000, 16'h3C3C, 16'h0000, 1, 1'b1);
      repeat (30) @(posedge clk);
      #1;
      chk(busy_o == 1'b0, "R10 late request not started afterwards", busy_o, 0);
      chk(disp_dout_o == 16'h3C3C, "R10 display data kept", disp_dout_o, 16'h3C3C);

      // R7: a write does not disturb captured read data; a new read replaces it
      do_op(1'b0, 26'h3F00200, 16'h0000, 16'h9000, 2, 1'b0);
      do_op(1'b1, 26'h3F00200, 16'h5A5A, 16'h0000, 2, 1'b0);
      chk(rdata_o == 16'h9003, "R7 read data held after write", rdata_o, 16'h9003);

      // back-to-back reset followed by a data read
      do_op(1'b1, 26'h3F00100, 16'h0000, 16'h0000, 3, 1'b0);
      do_op(1'b0, 26'h3F00000, 16'h0000, 16'h0100, 1, 1'b0);

      finish_run();
   end

endmodule